// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block manages one port of 32 general-purpose I/O pins. Each pin has one of three owners: the port controller, peripheral A or peripheral B. While the controller owns a pin, the pad output value and output enable come from the controller's own data and direction words. While a peripheral owns a pin, the selected peripheral's output value and output enable reach the pad unchanged. Every pin also has a pull-up enable flag, and the pad input word goes to both peripherals at all times.

Software reaches the block through a plain register bus with an address, a write strobe, write data, a read strobe and read data. Each setting has three addresses. A set-only address turns on the bits written as 1. A clear-only address turns them off. A read-only status address returns the current word. Bits written as 0 leave their pins unchanged. The output data word can also be written directly, but only the bits whose direct-write permission is on take the new value. The bus has no handshake. A write takes effect at the clock edge where the write strobe is sampled. Read data is registered and is valid in the cycle after the read strobe. That cycle cannot be stalled, so there is no back-pressure.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, all pins are owned by the controller, every direction bit is 0 (input), the peripheral selection is 0 (A) for every pin, the output data is 0, all direct-write permissions are 0, and all pull-ups are 1. As a result, pad_oe and pad_out are 0 and pad_pu is all ones.
- R2: A write to address 0 gives the pins written as 1 to the controller. A write to address 1 releases them to a peripheral. Address 2 reads the ownership word, where 1 means the controller owns the pin. Bits written as 0 leave their pins unchanged.
- R3: A write to address 7 selects peripheral B for the bits written as 1. A write to address 6 selects peripheral A for them. Address 8 reads the selection word, where 0 means A and 1 means B.
- R4: A write to address 3 sets direction bits and a write to address 4 clears them. Address 5 reads the direction word. On a controller-owned pin, pad_oe equals its direction bit.
- R5: A write to address 9 sets output data bits and a write to address 10 clears them. Address 11 reads the data word. On a controller-owned pin, pad_out equals its data bit.
- R6: A write to address 11 changes only the data bits whose direct-write permission is 1 and leaves all other bits unchanged. A write to address 12 turns permissions on, a write to address 13 turns them off, and address 14 reads the permission word.
- R7: A write to address 15 sets pull-up bits and a write to address 16 clears them. Address 17 reads the pull-up word (1 = on), and pad_pu equals that word at all times.
- R8: On a pin that a peripheral owns, pad_out and pad_oe follow the selected peripheral's output value and output enable. The controller's data and direction bits have no effect on that pin.
- R9: per_a_in and per_b_in both equal pad_in at all times, whatever the ownership.
- R10: bus_rdata holds the addressed status word in the cycle after bus_rd. It holds 0 when the address is set-only, clear-only or unmapped (18 to 31), and 0 when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input values |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pad pull-up enables |
| per_a_out | input | 32 | Peripheral A output values |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_a_in | output | 32 | Pad inputs to peripheral A |
| per_b_out | input | 32 | Peripheral B output values |
| per_b_oe | input | 32 | Peripheral B output enables |
| per_b_in | output | 32 | Pad inputs to peripheral B |

## Verification
The bench writes set and clear words that overlap bits already on. A design that cleared or copied the whole word, instead of acting only on the 1 bits, would read back the wrong status. It writes the data word directly first with no permission and then with a partial permission. A design that ignored the mask would change pins it must not touch. It hands pins to each peripheral while the controller's data and direction bits hold values opposite to the peripheral's. Any leak of controller state, or a swapped A/B selection, then shows at the pads. It also reads set-only and unmapped addresses. A design that decoded these addresses loosely would return a register's contents in place of 0.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [REG_AW-1:0] {
    A_OWN_SET  = 5'd0,
    A_OWN_CLR  = 5'd1,
    A_OWN_STAT = 5'd2,
    A_DIR_SET  = 5'd3,
    A_DIR_CLR  = 5'd4,
    A_DIR_STAT = 5'd5,
    A_SEL_A    = 5'd6,
    A_SEL_B    = 5'd7,
    A_SEL_STAT = 5'd8,
    A_DAT_SET  = 5'd9,
    A_DAT_CLR  = 5'd10,
    A_DAT_WORD = 5'd11,
    A_WPM_SET  = 5'd12,
    A_WPM_CLR  = 5'd13,
    A_WPM_STAT = 5'd14,
    A_PU_SET   = 5'd15,
    A_PU_CLR   = 5'd16,
    A_PU_STAT  = 5'd17
  } gpio_addr_e;
endpackage

// File: rtl/gpio_setclr_reg.sv
// One configuration word: set-only, clear-only and optional masked load.
module gpio_setclr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         ld_we,
  input  logic [W-1:0] ld_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (set_we) q <= q | wdata;
    else if (clr_we) q <= q & ~wdata;
    else if (ld_we)  q <= (q & ~ld_mask) | (wdata & ld_mask);
  end
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin choice of the pad drive between controller, peripheral A and B.
module gpio_pin_mux #(
  parameter int N = 32
) (
  input  logic [N-1:0] own_ctl,
  input  logic [N-1:0] sel_b,
  input  logic [N-1:0] ctl_out,
  input  logic [N-1:0] ctl_oe,
  input  logic [N-1:0] a_out,
  input  logic [N-1:0] a_oe,
  input  logic [N-1:0] b_out,
  input  logic [N-1:0] b_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      if (own_ctl[i]) begin
        pad_out[i] = ctl_out[i];
        pad_oe[i]  = ctl_oe[i];
      end else if (sel_b[i]) begin
        pad_out[i] = b_out[i];
        pad_oe[i]  = b_oe[i];
      end else begin
        pad_out[i] = a_out[i];
        pad_oe[i]  = a_oe[i];
      end
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  input  logic [NPINS-1:0]  per_a_out,
  input  logic [NPINS-1:0]  per_a_oe,
  output logic [NPINS-1:0]  per_a_in,
  input  logic [NPINS-1:0]  per_b_out,
  input  logic [NPINS-1:0]  per_b_oe,
  output logic [NPINS-1:0]  per_b_in
);
  localparam logic [NPINS-1:0] ALL1 = '1;
  localparam logic [NPINS-1:0] ALL0 = '0;

  logic [NPINS-1:0] own_q, dir_q, sel_q, dat_q, wpm_q, pu_q;

  function automatic logic hit(input logic [REG_AW-1:0] a, input gpio_addr_e r);
    return a == r;
  endfunction

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_own (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_OWN_SET)),
    .clr_we(bus_wr && hit(bus_addr, A_OWN_CLR)),
    .ld_we(1'b0), .ld_mask(ALL0), .wdata(bus_wdata), .q(own_q));

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_dir (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_DIR_SET)),
    .clr_we(bus_wr && hit(bus_addr, A_DIR_CLR)),
    .ld_we(1'b0), .ld_mask(ALL0), .wdata(bus_wdata), .q(dir_q));

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_sel (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_SEL_B)),
    .clr_we(bus_wr && hit(bus_addr, A_SEL_A)),
    .ld_we(1'b0), .ld_mask(ALL0), .wdata(bus_wdata), .q(sel_q));

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_wpm (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_WPM_SET)),
    .clr_we(bus_wr && hit(bus_addr, A_WPM_CLR)),
    .ld_we(1'b0), .ld_mask(ALL0), .wdata(bus_wdata), .q(wpm_q));

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_dat (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_DAT_SET)),
    .clr_we(bus_wr && hit(bus_addr, A_DAT_CLR)),
    .ld_we(bus_wr && hit(bus_addr, A_DAT_WORD)),
    .ld_mask(wpm_q), .wdata(bus_wdata), .q(dat_q));

  gpio_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_pu (
    .clk, .rst_n,
    .set_we(bus_wr && hit(bus_addr, A_PU_SET)),
    .clr_we(bus_wr && hit(bus_addr, A_PU_CLR)),
    .ld_we(1'b0), .ld_mask(ALL0), .wdata(bus_wdata), .q(pu_q));

  gpio_pin_mux #(.N(NPINS)) u_mux (
    .own_ctl(own_q), .sel_b(sel_q),
    .ctl_out(dat_q), .ctl_oe(dir_q),
    .a_out(per_a_out), .a_oe(per_a_oe),
    .b_out(per_b_out), .b_oe(per_b_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  assign pad_pu   = pu_q;
  assign per_a_in = pad_in;
  assign per_b_in = pad_in;

  // Registered read port; write-only and unmapped addresses read as zero.
  always_ff @(posedge clk) begin
    if (!rst_n || !bus_rd) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_OWN_STAT: bus_rdata <= own_q;
        A_DIR_STAT: bus_rdata <= dir_q;
        A_SEL_STAT: bus_rdata <= sel_q;
        A_DAT_WORD: bus_rdata <= dat_q;
        A_WPM_STAT: bus_rdata <= wpm_q;
        A_PU_STAT:  bus_rdata <= pu_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_pu,
  input logic [NPINS-1:0]  own_q,
  input logic [NPINS-1:0]  sel_q,
  input logic [NPINS-1:0]  dat_q,
  input logic [NPINS-1:0]  wpm_q
);
  assert_own_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OWN_SET) |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_selb_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SEL_B) |=> ((sel_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_masked_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DAT_WORD) |=> (((dat_q ^ $past(dat_q)) & ~$past(wpm_q)) == '0));

  assert_pu_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_pu));

  assert_wo_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_OWN_SET || bus_addr == A_DAT_SET || bus_addr > A_PU_STAT))
      |=> (bus_rdata == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pad_pu(pad_pu), .own_q(own_q), .sel_q(sel_q), .dat_q(dat_q), .wpm_q(wpm_q));

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
  logic [31:0] per_a_in, per_b_in;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .pad_pu,
    .per_a_out, .per_a_oe, .per_a_in, .per_b_out, .per_b_oe, .per_b_in);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd2,  v); check("R1 own", v, 32'hFFFF_FFFF);
    rd(5'd5,  v); check("R1 dir", v, 32'h0);
    rd(5'd8,  v); check("R1 sel", v, 32'h0);
    rd(5'd11, v); check("R1 dat", v, 32'h0);
    rd(5'd14, v); check("R1 wpm", v, 32'h0);
    rd(5'd17, v); check("R1 pu", v, 32'hFFFF_FFFF);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_pu", pad_pu, 32'hFFFF_FFFF);
    @(negedge clk); check("R10 idle rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_owner_sel();
    logic [31:0] v;
    wr(5'd1, 32'h0000_00F0); rd(5'd2, v); check("R2 release", v, 32'hFFFF_FF0F);
    wr(5'd0, 32'h0000_0010); rd(5'd2, v); check("R2 partial take", v, 32'hFFFF_FF1F);
    wr(5'd0, 32'hFFFF_FFFF); rd(5'd2, v); check("R2 take all", v, 32'hFFFF_FFFF);
    wr(5'd7, 32'h0000_0F00); rd(5'd8, v); check("R3 sel b", v, 32'h0000_0F00);
    wr(5'd6, 32'h0000_0300); rd(5'd8, v); check("R3 sel a", v, 32'h0000_0C00);
  endtask

  task automatic t_dir_data();
    logic [31:0] v;
    wr(5'd3, 32'h0000_00FF); wr(5'd9, 32'h0000_00A5);
    check("R4 pad_oe", pad_oe, 32'h0000_00FF);
    check("R5 pad_out", pad_out, 32'h0000_00A5);
    wr(5'd10, 32'h0000_0005); rd(5'd11, v); check("R5 clear", v, 32'h0000_00A0);
    check("R5 pad_out clr", pad_out, 32'h0000_00A0);
    wr(5'd4, 32'h0000_000F); rd(5'd5, v); check("R4 dir stat", v, 32'h0000_00F0);
    check("R4 pad_oe clr", pad_oe, 32'h0000_00F0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(5'd11, 32'hFFFF_FFFF); rd(5'd11, v); check("R6 no permission", v, 32'h0000_00A0);
    wr(5'd12, 32'h0000_FF00); rd(5'd14, v); check("R6 wpm stat", v, 32'h0000_FF00);
    wr(5'd11, 32'h1234_5678); rd(5'd11, v); check("R6 masked load", v, 32'h0000_56A0);
    wr(5'd13, 32'h0000_F000); rd(5'd14, v); check("R6 wpm clr", v, 32'h0000_0F00);
    wr(5'd11, 32'h0); rd(5'd11, v); check("R6 masked load 2", v, 32'h0000_50A0);
  endtask

  task automatic t_pullup();
    logic [31:0] v;
    wr(5'd16, 32'hF000_0000); rd(5'd17, v); check("R7 pu stat", v, 32'h0FFF_FFFF);
    check("R7 pad_pu", pad_pu, 32'h0FFF_FFFF);
    wr(5'd15, 32'h1000_0000); check("R7 pad_pu set", pad_pu, 32'h1FFF_FFFF);
  endtask

  task automatic t_periph();
    // data low nibble 0, dir low nibble 0 at entry
    per_a_out = 32'h0000_0005; per_a_oe = 32'h0000_0003;
    per_b_out = 32'hFFFF_FFFF; per_b_oe = 32'hFFFF_FFFF;
    wr(5'd1, 32'h0000_000F);
    check("R8 a out", pad_out & 32'hFF, 32'h0000_00A5);
    check("R8 a oe", pad_oe & 32'hFF, 32'h0000_00F3);
    wr(5'd7, 32'h0000_000F);
    check("R8 b out", pad_out & 32'hFF, 32'h0000_00AF);
    check("R8 b oe", pad_oe & 32'hFF, 32'h0000_00FF);
    wr(5'd9, 32'h0000_000F); wr(5'd4, 32'h0000_00FF);
    per_b_out = 32'hFFFF_FFF0; per_b_oe = 32'hFFFF_FFF0;
    @(negedge clk);
    check("R8 ctl no effect out", pad_out & 32'hFF, 32'h0000_00A0);
    check("R8 ctl no effect oe", pad_oe & 32'hFF, 32'h0000_0000);
  endtask

  task automatic t_inputs_reads();
    logic [31:0] v;
    pad_in = 32'hDEAD_BEEF; #1;
    check("R9 a in", per_a_in, 32'hDEAD_BEEF);
    check("R9 b in", per_b_in, 32'hDEAD_BEEF);
    pad_in = 32'h1357_9BDF; #1;
    check("R9 b in 2", per_b_in, 32'h1357_9BDF);
    rd(5'd0, v);  check("R10 set addr", v, 32'h0);
    rd(5'd9, v);  check("R10 data set addr", v, 32'h0);
    rd(5'd25, v); check("R10 unmapped", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_owner_sel();
    t_dir_data();
    t_direct();
    t_pullup();
    t_periph();
    t_inputs_reads();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule